// File: doc/BRIEF.md
# Video Input Framing Window Generator

This block turns the raw horizontal and vertical sync pulses of a digital video input into framing flags for the pixel pipeline behind it. Each sync input gets its own polarity select and passes through a two-stage synchronizer. A shared low-active enable decides whether sync leading edges are accepted. After that, a pixel counter and a line counter place a rectangular active window inside each field.

The window is set by coarse-grained fields. The horizontal start is a 4-clock coarse delay plus a 1-clock fine delay. The line width is given in units of 8 clocks. The vertical start is a line delay, and the field height is given in units of 2 lines. A fixed processing delay `PD` is added to both start offsets. The block takes a copy of the window fields at every accepted vertical sync, so a field is always framed with one consistent setting. The block also watches the spacing of horizontal syncs and keeps a sticky flag when a line measures an odd number of clocks.

Top module: `vfw_frame_gen`

## Requirements
- R1: A sync input counts as active when it equals its polarity bit (1: high active, 0: low active). Only the leading edge into the active level is used, and a sync held active produces a single edge.
- R2: While `sync_en_n` is 1, sync leading edges are ignored. No strobe is produced, and neither the pixel count, the line count nor the window setting changes.
- R3: Let E be the clock edge that first samples an accepted horizontal leading edge, and S = 4*`h_coarse` + `h_fine` + PD. `h_active` is 1 for exactly 8*`h_units` consecutive cycles, and the first of them is the cycle after edge E+3+S.
- R4: Lines are indexed from the accepted vertical edge. An horizontal edge in the same clock as it is line 0, and each later horizontal edge adds 1. `v_active` is 1 for lines with index in [`v_delay`+PD, `v_delay`+PD+2*`v_units`), and it takes a line's value from the cycle after edge E+3 of that line.
- R5: `data_valid` is 1 exactly when `h_active` and `v_active` are both 1. `line_start` is a one-cycle pulse on the first `h_active` cycle of each line, and it does not appear when `h_units` is 0.
- R6: `field_start` is a one-cycle pulse in the cycle after edge E+3, where E is the edge that samples an accepted vertical leading edge.
- R7: An horizontal sync that arrives before the window has ended cuts the window short, and timing restarts from the new edge.
- R8: A vertical sync in the middle of a field resets the line index to 0 and starts a new field.
- R9: The window fields are copied at reset and at each accepted vertical edge. A change on those ports takes effect only from the next accepted vertical sync.
- R10: When the spacing between two accepted horizontal edges is an odd number of clocks, `line_len_err` goes to 1 and stays there until reset.
- R11: During and right after synchronous reset, all six outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| hsync_in | input | 1 | Raw horizontal sync |
| vsync_in | input | 1 | Raw vertical sync |
| sync_en_n | input | 1 | Low-active qualifier for both syncs |
| hsync_pol | input | 1 | Horizontal sync active level |
| vsync_pol | input | 1 | Vertical sync active level |
| h_coarse | input | 6 | Horizontal start delay, units of 4 clocks |
| h_fine | input | 1 | Extra horizontal start delay of 1 clock |
| h_units | input | 7 | Active line width, units of 8 clocks |
| v_delay | input | 6 | Vertical start delay in lines |
| v_units | input | 8 | Active field height, units of 2 lines |
| h_active | output | 1 | Inside the horizontal window |
| v_active | output | 1 | Inside the vertical window |
| data_valid | output | 1 | Inside both windows |
| line_start | output | 1 | First active clock of a line |
| field_start | output | 1 | Start of a new field |
| line_len_err | output | 1 | Sticky odd-line-length flag |

## Verification
The strobe properties rely on PD being at least 1. They also rely on line and field counts staying below the counter limits, so that a window never starts at count zero or wraps. The bench only drives lines of even length, except in the single odd-length test that comes last. Sync pulses are two clocks wide and never overlap an enable change. Polarity and window ports change only while the syncs are idle or in the middle of a line, so every accepted edge has a clear meaning.

// File: rtl/vfw_pkg.sv
package vfw_pkg;

    localparam int unsigned COARSE_W = 6;
    localparam int unsigned HUNIT_W  = 7;
    localparam int unsigned VDLY_W   = 6;
    localparam int unsigned VUNIT_W  = 8;

    typedef struct packed {
        logic [COARSE_W-1:0] coarse;
        logic                fine;
        logic [HUNIT_W-1:0]  units;
    } h_cfg_t;

    typedef struct packed {
        logic [VDLY_W-1:0]  delay;
        logic [VUNIT_W-1:0] units;
    } v_cfg_t;

    function automatic int unsigned h_first_pos(h_cfg_t c, int unsigned pd);
        return 32'(c.coarse) * 32'd4 + 32'(c.fine) + pd;
    endfunction

    function automatic int unsigned h_end_pos(h_cfg_t c, int unsigned pd);
        return h_first_pos(c, pd) + 32'(c.units) * 32'd8;
    endfunction

    function automatic int unsigned v_first_line(v_cfg_t c, int unsigned pd);
        return 32'(c.delay) + pd;
    endfunction

    function automatic int unsigned v_end_line(v_cfg_t c, int unsigned pd);
        return v_first_line(c, pd) + 32'(c.units) * 32'd2;
    endfunction

endpackage

// File: rtl/vfw_sync_edge.sv
module vfw_sync_edge #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic raw,
    input  logic pol,
    input  logic en_n,
    output logic lead
);
    localparam int unsigned LAST = STAGES - 1;

    logic             act;
    logic [LAST:0]    lvl_q;
    logic [LAST:0]    dis_q;
    logic             prev_q;

    // Polarity is folded in ahead of the synchronizer so a polarity change
    // travels with the data and cannot fake an edge.
    assign act = ~(raw ^ pol);

    always_ff @(posedge clk) begin
        if (rst) begin
            lvl_q  <= '0;
            dis_q  <= '0;
            prev_q <= 1'b0;
        end else begin
            lvl_q  <= {lvl_q[LAST-1:0], act};
            dis_q  <= {dis_q[LAST-1:0], en_n};
            prev_q <= lvl_q[LAST];
        end
    end

    assign lead = lvl_q[LAST] & ~prev_q & ~dis_q[LAST];

    AST_EDGE_PULSE: assert property (@(posedge clk) disable iff (rst)
        lead |=> !lead) else $error("edge lasted more than one cycle"); // R1

endmodule

// File: rtl/vfw_hcount.sv
module vfw_hcount
    import vfw_pkg::*;
#(
    parameter int unsigned PD     = 2,
    parameter int unsigned CNT_W  = 12
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   hs_lead,
    input  h_cfg_t cfg,
    output logic   h_win,
    output logic   h_first,
    output logic   odd_err
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0] pos_q;
    logic             seen_q;
    int unsigned      pos;
    int unsigned      first_pos;
    int unsigned      end_pos;

    always_ff @(posedge clk) begin
        if (rst) begin
            pos_q   <= '0;
            seen_q  <= 1'b0;
            odd_err <= 1'b0;
        end else if (hs_lead) begin
            // spacing = pos_q + 1 clocks; odd spacing means even pos_q
            if (seen_q && pos_q != CNT_MAX && !pos_q[0])
                odd_err <= 1'b1;
            pos_q  <= '0;
            seen_q <= 1'b1;
        end else if (pos_q != CNT_MAX) begin
            pos_q <= pos_q + 1'b1;
        end
    end

    assign pos       = 32'(pos_q);
    assign first_pos = h_first_pos(cfg, PD);
    assign end_pos   = h_end_pos(cfg, PD);

    assign h_win   = seen_q && (pos >= first_pos) && (pos < end_pos);
    assign h_first = seen_q && (cfg.units != '0) && (pos == first_pos);

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
        odd_err |=> odd_err) else $error("length error flag dropped"); // R10

endmodule

// File: rtl/vfw_vcount.sv
module vfw_vcount
    import vfw_pkg::*;
#(
    parameter int unsigned PD    = 2,
    parameter int unsigned CNT_W = 11
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   vs_lead,
    input  logic   hs_lead,
    input  v_cfg_t cfg,
    output logic   v_win
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0] line_q;
    logic             seen_q;
    int unsigned      line_idx;

    always_ff @(posedge clk) begin
        if (rst) begin
            line_q <= '0;
            seen_q <= 1'b0;
        end else if (vs_lead) begin
            line_q <= '0;
            seen_q <= 1'b1;
        end else if (hs_lead && line_q != CNT_MAX) begin
            line_q <= line_q + 1'b1;
        end
    end

    assign line_idx = 32'(line_q);
    assign v_win = seen_q && (line_idx >= v_first_line(cfg, PD))
                          && (line_idx <  v_end_line(cfg, PD));

endmodule

// File: rtl/vfw_frame_gen.sv
module vfw_frame_gen
    import vfw_pkg::*;
#(
    parameter int unsigned PD          = 2,
    parameter int unsigned HCNT_W      = 12,
    parameter int unsigned VCNT_W      = 11,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                hsync_in,
    input  logic                vsync_in,
    input  logic                sync_en_n,
    input  logic                hsync_pol,
    input  logic                vsync_pol,
    input  logic [COARSE_W-1:0] h_coarse,
    input  logic                h_fine,
    input  logic [HUNIT_W-1:0]  h_units,
    input  logic [VDLY_W-1:0]   v_delay,
    input  logic [VUNIT_W-1:0]  v_units,
    output logic                h_active,
    output logic                v_active,
    output logic                data_valid,
    output logic                line_start,
    output logic                field_start,
    output logic                line_len_err
);
    logic   hs_lead, vs_lead;
    h_cfg_t h_cfg_q;
    v_cfg_t v_cfg_q;
    logic   h_win, h_first, v_win;
    logic   fs_d1;

    vfw_sync_edge #(.STAGES(SYNC_STAGES)) u_hsync (
        .clk(clk), .rst(rst), .raw(hsync_in), .pol(hsync_pol),
        .en_n(sync_en_n), .lead(hs_lead)
    );

    vfw_sync_edge #(.STAGES(SYNC_STAGES)) u_vsync (
        .clk(clk), .rst(rst), .raw(vsync_in), .pol(vsync_pol),
        .en_n(sync_en_n), .lead(vs_lead)
    );

    // Window setting is frozen per field.
    always_ff @(posedge clk) begin
        if (rst || vs_lead) begin
            h_cfg_q <= '{coarse: h_coarse, fine: h_fine, units: h_units};
            v_cfg_q <= '{delay: v_delay, units: v_units};
        end
    end

    vfw_hcount #(.PD(PD), .CNT_W(HCNT_W)) u_hcount (
        .clk(clk), .rst(rst), .hs_lead(hs_lead), .cfg(h_cfg_q),
        .h_win(h_win), .h_first(h_first), .odd_err(line_len_err)
    );

    vfw_vcount #(.PD(PD), .CNT_W(VCNT_W)) u_vcount (
        .clk(clk), .rst(rst), .vs_lead(vs_lead), .hs_lead(hs_lead),
        .cfg(v_cfg_q), .v_win(v_win)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            h_active    <= 1'b0;
            v_active    <= 1'b0;
            data_valid  <= 1'b0;
            line_start  <= 1'b0;
            fs_d1       <= 1'b0;
            field_start <= 1'b0;
        end else begin
            h_active    <= h_win;
            v_active    <= v_win;
            data_valid  <= h_win & v_win;
            line_start  <= h_first;
            fs_d1       <= vs_lead;
            field_start <= fs_d1;
        end
    end

    AST_DV_BOTH: assert property (@(posedge clk) disable iff (rst)
        data_valid |-> (h_active && v_active)) else $error("valid outside window"); // R5

    AST_LS_FIRST: assert property (@(posedge clk) disable iff (rst)
        line_start |-> (h_active && !$past(h_active))) else $error("line start misplaced"); // R5

    AST_FS_IDLE: assert property (@(posedge clk) disable iff (rst)
        field_start |-> !v_active) else $error("field start inside window"); // R6

endmodule

// File: tb/vfw_frame_gen_tb_top.sv
module vfw_frame_gen_tb_top;
    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic       rst = 1'b1;
    logic       hsync_in = 1'b0, vsync_in = 1'b0, sync_en_n = 1'b0;
    logic       hsync_pol = 1'b1, vsync_pol = 1'b1;
    logic [5:0] h_coarse = 6'd2;
    logic       h_fine = 1'b1;
    logic [6:0] h_units = 7'd2;
    logic [5:0] v_delay = 6'd1;
    logic [7:0] v_units = 8'd2;
    logic h_active, v_active, data_valid, line_start, field_start, line_len_err;

    vfw_frame_gen dut_i (
        .clk(clk), .rst(rst), .hsync_in(hsync_in), .vsync_in(vsync_in),
        .sync_en_n(sync_en_n), .hsync_pol(hsync_pol), .vsync_pol(vsync_pol),
        .h_coarse(h_coarse), .h_fine(h_fine), .h_units(h_units),
        .v_delay(v_delay), .v_units(v_units),
        .h_active(h_active), .v_active(v_active), .data_valid(data_valid),
        .line_start(line_start), .field_start(field_start),
        .line_len_err(line_len_err)
    );

    localparam int PDV = 2;
    int checks = 0, errors = 0;
    bit done = 0;

    // reference model state
    int since, line, l_hs0, l_hn, l_vs0, l_vm;
    bit hseen, vseen, err_exp, prev_ha, prev_va;
    logic [4:0] q0, q1, q2;  // {h, v, dv, ls, fs}
    int ls_cnt, fs_cnt, dv_cnt;

    task automatic chk(string req, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0b expected=%0b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic latch_cfg();
        l_hs0 = int'(h_coarse) * 4 + int'(h_fine) + PDV;
        l_hn  = int'(h_units);
        l_vs0 = int'(v_delay) + PDV;
        l_vm  = int'(v_units);
    endtask

    // Called at a falling edge; returns at the next falling edge.
    task automatic tick(bit ha, bit va, bit en_n);
        logic [4:0] nx;
        bit acc_h, acc_v, hw, vw;
        hsync_in  = ha ? hsync_pol : ~hsync_pol;
        vsync_in  = va ? vsync_pol : ~vsync_pol;
        sync_en_n = en_n;
        if (since < 4095) since++;
        acc_h = ha && !prev_ha && !en_n;
        acc_v = va && !prev_va && !en_n;
        prev_ha = ha;
        prev_va = va;
        if (acc_v) begin
            latch_cfg();
            vseen = 1;
            line = 0;
        end
        if (acc_h) begin
            if (hseen && (since % 2 == 1)) err_exp = 1;
            since = 0;
            hseen = 1;
            if (!acc_v && line < 2047) line++;
        end
        hw = hseen && since >= l_hs0 && since < l_hs0 + 8 * l_hn;
        vw = vseen && line >= l_vs0 && line < l_vs0 + 2 * l_vm;
        nx = {hw, vw, hw & vw, hseen && l_hn != 0 && since == l_hs0, acc_v};
        @(posedge clk);
        #2;
        chk("R3 h_active", h_active, q2[4]);
        chk("R4 v_active", v_active, q2[3]);
        chk("R5 data_valid", data_valid, q2[2]);
        chk("R5 line_start", line_start, q2[1]);
        chk("R6 field_start", field_start, q2[0]);
        if (line_start) ls_cnt++;
        if (field_start) fs_cnt++;
        if (data_valid) dv_cnt++;
        q2 = q1; q1 = q0; q0 = nx;
        @(negedge clk);
    endtask

    task automatic run_line(int len, bit with_vs, bit en_n);
        for (int j = 0; j < len; j++) tick(j < 2, with_vs && j < 2, en_n);
    endtask

    task automatic run_frame(int nlines, int len, bit en_n);
        for (int i = 0; i < nlines; i++) run_line(len, i == 0, en_n);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        hsync_in = ~hsync_pol; vsync_in = ~vsync_pol; sync_en_n = 1'b0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        since = 0; line = 0; hseen = 0; vseen = 0; err_exp = 0;
        prev_ha = 0; prev_va = 0; q0 = '0; q1 = '0; q2 = '0;
        latch_cfg();
    endtask

    task automatic test_reset();
        do_reset();
        chk("R11 h_active", h_active, 1'b0);
        chk("R11 v_active", v_active, 1'b0);
        chk("R11 data_valid", data_valid, 1'b0);
        chk("R11 line_start", line_start, 1'b0);
        chk("R11 field_start", field_start, 1'b0);
        chk("R11 line_len_err", line_len_err, 1'b0);
    endtask

    task automatic test_basic();
        run_frame(10, 40, 0);
        dv_cnt = 0; ls_cnt = 0; fs_cnt = 0;
        run_frame(10, 40, 0);
        // window 16 clocks x 4 lines
        checks++; if (dv_cnt != 64) begin errors++; $display("FAIL R5 valid count: actual=%0d expected=64", dv_cnt); end
        checks++; if (ls_cnt != 10) begin errors++; $display("FAIL R5 line starts: actual=%0d expected=10", ls_cnt); end
        checks++; if (fs_cnt != 1) begin errors++; $display("FAIL R6 field starts: actual=%0d expected=1", fs_cnt); end
    endtask

    task automatic test_polarity();
        hsync_pol = 1'b0; vsync_pol = 1'b0;   // R1 low-active syncs
        run_frame(10, 40, 0);
        run_frame(10, 40, 0);
        hsync_pol = 1'b1; vsync_pol = 1'b1;
        run_frame(10, 40, 0);
    endtask

    task automatic test_cfg_hold();
        run_line(40, 1, 0);
        run_line(40, 0, 0);
        h_coarse = 6'd0; h_fine = 1'b0; h_units = 7'd3;  // R9 not yet in force
        v_delay = 6'd0; v_units = 8'd1;
        for (int i = 0; i < 8; i++) run_line(40, 0, 0);
        run_frame(10, 40, 0);
    endtask

    task automatic test_early_hsync();
        h_coarse = 6'd5; h_fine = 1'b0; h_units = 7'd4;  // window 22..53, line 30: R7
        v_delay = 6'd1; v_units = 8'd2;
        run_frame(1, 40, 0);
        run_frame(8, 30, 0);
        run_frame(8, 30, 0);
    endtask

    task automatic test_midfield_vsync();
        h_coarse = 6'd2; h_fine = 1'b1; h_units = 7'd2;
        run_frame(10, 40, 0);
        run_frame(5, 40, 0);   // R8 cut field
        run_frame(10, 40, 0);
    endtask

    task automatic test_disabled();
        ls_cnt = 0; fs_cnt = 0;
        run_frame(4, 40, 1);   // R2 syncs ignored
        checks++; if (ls_cnt != 0) begin errors++; $display("FAIL R2 line starts: actual=%0d expected=0", ls_cnt); end
        checks++; if (fs_cnt != 0) begin errors++; $display("FAIL R2 field starts: actual=%0d expected=0", fs_cnt); end
        run_frame(10, 40, 0);
        chk("R2 no length error", line_len_err, 1'b0);
    endtask

    task automatic test_odd_length();
        chk("R10 clear before odd line", line_len_err, err_exp);
        run_line(41, 1, 0);
        run_line(40, 0, 0);
        run_line(40, 0, 0);
        chk("R10 set after odd line", line_len_err, 1'b1);
        run_frame(6, 40, 0);
        chk("R10 stays set", line_len_err, 1'b1);
    endtask

    initial begin
        test_reset();
        test_basic();
        test_polarity();
        test_cfg_hold();
        test_early_hsync();
        test_midfield_vsync();
        test_disabled();
        chk("R10 even lines", line_len_err, err_exp);
        test_odd_length();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        #4000000;
        if (!done) begin
            done = 1;
            checks++; errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule